// File: doc/BRIEF.md
# Multiplexed DRAM Address Steering and Bus Gating

This block takes the processor's full-width address and presents one half of it at a time on a half-width multiplexed DRAM address bus. A half-select strobe picks which half: low selects the upper half (the row half), high selects the lower half (the column half). The upper half travels first because the DRAM latches it first.

The video controller shares the memory bus with the processor. While the processor holds the bus grant, the block drives the multiplexed address. While the video controller holds the bus, the block releases the bus. The release is modelled as a data output plus an active-high output enable, so that a pad ring or tri-state driver outside the block can float the lines.

The block also gates the video controller's bus-grant and bus-free indications with an active-low external DMA request. The gated results are the processor's address-enable and ready inputs. Everything is combinational, so every output settles in the same cycle as the inputs that drive it.

Top module: `dram_addr_mux`

## Requirements
- R1: With `cpu_grant` high and `half_sel` low, `ma_out` equals `cpu_addr[ADDR_W-1:ADDR_W/2]` (upper half).
- R2: With `cpu_grant` high and `half_sel` high, `ma_out` equals `cpu_addr[ADDR_W/2-1:0]` (lower half).
- R3: `ma_oe` is high exactly when `cpu_grant` is high. When `cpu_grant` is low, the multiplexed bus is released.
- R4: While `ma_oe` is low, `ma_out` reads all zeros, so no stale address is left on the data side of the driver.
- R5: `cpu_bus_en` is high exactly when `cpu_grant` is high and `dma_req_n` is high.
- R6: `cpu_ready` is high exactly when `vid_bus_free` is high and `dma_req_n` is high.
- R7: While `dma_req_n` is low, `cpu_bus_en` and `cpu_ready` are both low, whatever the other inputs are.
- R8: With `dma_req_n` high (idle), `cpu_bus_en` follows `cpu_grant` and `cpu_ready` follows `vid_bus_free`. `dma_req_n` has no effect on `ma_out` or `ma_oe`.
- R9: All outputs respond combinationally. No clock edge is needed between an input change and the matching output value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_addr | input | ADDR_W | Processor address |
| half_sel | input | 1 | 0 = upper (row) half, 1 = lower (column) half |
| cpu_grant | input | 1 | 1 = processor owns the bus, 0 = video controller owns it |
| vid_bus_free | input | 1 | Video controller signals the bus is free for the processor |
| dma_req_n | input | 1 | Active-low external DMA request, high when idle |
| ma_out | output | ADDR_W/2 | Multiplexed DRAM address data |
| ma_oe | output | 1 | Output enable for the multiplexed address bus |
| cpu_bus_en | output | 1 | Gated processor address enable |
| cpu_ready | output | 1 | Gated processor ready |

## Verification
The bench builds the block with its default 16-bit address. This makes each half a full byte, so random addresses give upper and lower halves that differ, and a wrong half-select shows up at once. A directed sweep covers all sixteen combinations of grant, half-select, bus-free and DMA request, using patterns whose halves are complementary. A fixed-seed random phase then covers the rest.

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                half_sel,
  input  logic                cpu_grant,
  input  logic                vid_bus_free,
  input  logic                dma_req_n,
  output logic [ADDR_W/2-1:0] ma_out,
  output logic                ma_oe,
  output logic                cpu_bus_en,
  output logic                cpu_ready
);
  localparam int HALF_W = ADDR_W / 2;

  logic [HALF_W-1:0] row_half;
  logic [HALF_W-1:0] col_half;
  logic [HALF_W-1:0] picked;

  assign row_half = cpu_addr[ADDR_W-1:HALF_W];
  assign col_half = cpu_addr[HALF_W-1:0];
  assign picked   = half_sel ? col_half : row_half;

  assign ma_oe  = cpu_grant;
  assign ma_out = cpu_grant ? picked : '0;

  assign cpu_bus_en = cpu_grant & dma_req_n;
  assign cpu_ready  = vid_bus_free & dma_req_n;
endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk #(
  parameter int ADDR_W = 16
) (
  input logic [ADDR_W-1:0]   cpu_addr,
  input logic                half_sel,
  input logic                cpu_grant,
  input logic                vid_bus_free,
  input logic                dma_req_n,
  input logic [ADDR_W/2-1:0] ma_out,
  input logic                ma_oe,
  input logic                cpu_bus_en,
  input logic                cpu_ready
);
  localparam int HALF_W = ADDR_W / 2;

  always_comb begin
    if (!$isunknown({cpu_addr, half_sel, cpu_grant, vid_bus_free, dma_req_n})) begin
      if (ma_oe && !half_sel)
        assert_row_half_R1: assert (ma_out == cpu_addr[ADDR_W-1:HALF_W]);
      if (ma_oe && half_sel)
        assert_col_half_R2: assert (ma_out == cpu_addr[HALF_W-1:0]);
      if (!cpu_grant)
        assert_release_R3: assert (!ma_oe);
      if (!ma_oe)
        assert_quiet_data_R4: assert (ma_out == '0);
      if (cpu_bus_en)
        assert_en_needs_grant_R5: assert (cpu_grant && dma_req_n);
      if (cpu_ready)
        assert_rdy_needs_free_R6: assert (vid_bus_free && dma_req_n);
      if (!dma_req_n)
        assert_dma_blocks_R7: assert (!cpu_bus_en && !cpu_ready);
      if (dma_req_n)
        assert_idle_follow_R8: assert (cpu_bus_en == cpu_grant && cpu_ready == vid_bus_free);
    end
  end
endmodule

bind dram_addr_mux dram_addr_mux_chk #(.ADDR_W(ADDR_W)) u_chk (
  .cpu_addr(cpu_addr), .half_sel(half_sel), .cpu_grant(cpu_grant),
  .vid_bus_free(vid_bus_free), .dma_req_n(dma_req_n), .ma_out(ma_out),
  .ma_oe(ma_oe), .cpu_bus_en(cpu_bus_en), .cpu_ready(cpu_ready)
);

// File: tb/sim_dram_addr_mux.sv
`timescale 1ns/1ps
module sim_dram_addr_mux;
  localparam int AW = 16;
  localparam int HW = AW / 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] cpu_addr;
  logic          half_sel, cpu_grant, vid_bus_free, dma_req_n;
  logic [HW-1:0] ma_out;
  logic          ma_oe, cpu_bus_en, cpu_ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  dram_addr_mux #(.ADDR_W(AW)) u0 (
    .cpu_addr(cpu_addr), .half_sel(half_sel), .cpu_grant(cpu_grant),
    .vid_bus_free(vid_bus_free), .dma_req_n(dma_req_n), .ma_out(ma_out),
    .ma_oe(ma_oe), .cpu_bus_en(cpu_bus_en), .cpu_ready(cpu_ready)
  );

  function automatic logic [HW-1:0] exp_ma(logic [AW-1:0] a, logic s, logic g);
    if (!g) return '0;
    return s ? a[HW-1:0] : HW'(a >> HW);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [AW-1:0] a, logic s, logic g, logic b, logic d);
    @(negedge clk);
    cpu_addr = a; half_sel = s; cpu_grant = g; vid_bus_free = b; dma_req_n = d;
    #1;
    if (g && !s) chk("R1", 32'(ma_out), 32'(exp_ma(a, s, g)));
    else if (g)  chk("R2", 32'(ma_out), 32'(exp_ma(a, s, g)));
    else         chk("R4", 32'(ma_out), 32'(exp_ma(a, s, g)));
    chk("R3", 32'(ma_oe), 32'(g));
    chk("R5", 32'(cpu_bus_en), 32'(g & d));
    chk("R6", 32'(cpu_ready), 32'(b & d));
    if (!d) chk("R7", 32'({cpu_bus_en, cpu_ready}), 32'd0);
    else    chk("R8", 32'({cpu_bus_en, cpu_ready}), 32'({g, b}));
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed;
    logic [HW-1:0] keep_ma;
    logic          keep_oe;
    void'($urandom(seed));
    cpu_addr = '0; half_sel = 0; cpu_grant = 0; vid_bus_free = 0; dma_req_n = 1;
    #1;
    chk("R3 initial", 32'(ma_oe), 32'd0);
    chk("R4 initial", 32'(ma_out), 32'd0);
    chk("R6 initial", 32'({cpu_bus_en, cpu_ready}), 32'd0);

    for (int c = 0; c < 16; c++) begin
      apply(16'hA55A, c[0], c[1], c[2], c[3]);
      apply(16'h0FF0, c[0], c[1], c[2], c[3]);
    end

    // R9: same-cycle response, no clock edge between input change and check
    @(negedge clk);
    cpu_addr = 16'h1234; half_sel = 0; cpu_grant = 1; dma_req_n = 1; vid_bus_free = 1;
    #0.5;
    chk("R9 row", 32'(ma_out), 32'h12);
    half_sel = 1;
    #0.5;
    chk("R9 col", 32'(ma_out), 32'h34);

    // R8: DMA toggling leaves the address side untouched
    keep_ma = ma_out; keep_oe = ma_oe;
    dma_req_n = 0;
    #0.5;
    chk("R8 ma stable", 32'({keep_oe, keep_ma}), 32'({ma_oe, ma_out}));
    chk("R7 blocked", 32'({cpu_bus_en, cpu_ready}), 32'd0);

    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom());
      apply(AW'($urandom()), r[0], r[1], r[2], (i % 5 == 0) ? 1'b0 : r[3]);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule